// File: doc/BRIEF.md
# Indexed Register Access Target for a Two-Wire Management Bus

This block is an SMBus target that lets a host reach a small byte-wide control register file. The block runs on a fast system clock and oversamples the bus wires. It drives SDA only by pulling it low. Each transaction names a starting register index and, for writes, a byte count. The index then steps forward by one after every data byte. It wraps from the last index (63) back to 0.

A write transaction carries the write address byte, then the index, then a count N, then N data bytes. A read transaction first sends the write address byte and the index. It then uses a repeated START and the read address byte. The target answers with the value of its block-read count register, then streams register bytes from the index until the host declines a byte. Accessing a single byte is a block access of length one. The control register contents appear on a flat output bus so that neighbouring logic can use them.

Top module: `smbus_idx_target`

## Requirements
- R1: The 7-bit target address is 69h, so the address bytes D2h (write) and D3h (read) are acknowledged. Any other address byte is not acknowledged, and SDA stays released until the next START or STOP.
- R2: In a write, the index byte and a nonzero count N are acknowledged. The next N data bytes are each acknowledged and stored at the index, index+1, and so on.
- R3: A count byte of 00h is not acknowledged. No data byte is acknowledged or stored until the next START.
- R4: Data bytes beyond the count N in a write are not acknowledged and change no register.
- R5: In a read, the target first returns the block-read count register (index 8). It then returns register bytes starting at the index, in ascending order.
- R6: A not-acknowledge from the host ends the read: SDA is released for the rest of the transaction, and a STOP returns the target to idle.
- R7: The block-read count register at index 8 resets to 08h and can be written.
- R8: At index 6, bits 2:0 read back the three strap inputs latched while reset is asserted, and writes to those bits are ignored. Bits 7:3 are writable.
- R9: Index 7 reads 05h (revision 0 in bits 7:4, vendor 5 in bits 3:0). Index 62 reads 20h and index 63 reads 15h. Writes to these three indices are acknowledged and have no effect.
- R10: Indices 14 to 61 are unimplemented: writes to them are acknowledged and ignored, and reads return 00h.
- R11: The index advances after every accepted data byte and every data byte sent. It wraps from 63 to 0. The top two bits of the index byte are ignored.
- R12: After reset, SDA is released and indices 0 to 13 hold FFh, FEh, FFh, 00h, 0Fh, 00h, 38h with the straps in bits 2:0, 05h, 08h, 11h, 96h, 96h, A7h, 00h.
- R13: The target changes SDA only after a falling SCL edge or a START/STOP condition, never while SCL is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low reset; straps are latched while it is low |
| sclIn | input | 1 | Bus clock wire as seen at the pad |
| sdaIn | input | 1 | Bus data wire as seen at the pad |
| strapIn | input | 3 | Frequency-select strap inputs |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it |
| ctrlRegs | output | 112 | Indices 0 to 13 as read, index i in bits 8i+7:8i |

## Verification
Write tests use an ordinary run, a run that crosses the 63-to-0 wrap, a run with more data than its count, and a zero count. Together they separate correct storage and pointer stepping from the two rejection paths. Reads start at a plain index, at the identification bytes above the wrap, and at an unimplemented index. This shows whether the count byte comes first and whether data comes from the right place. Writes to the strap and identification indices, and a foreign address byte, show that protected state and other targets are left alone. A behavioural model of every register is compared with the output bus on each clock.

// File: rtl/smb_idx_pkg.sv
`timescale 1ns/1ps
package smb_idx_pkg;

  // Bus conditions seen after synchronisation, one-cycle pulses
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } busEvt_t;

  // Strobes from control to the register datapath
  typedef struct packed {
    logic       setOffset;
    logic       wrData;
    logic       rdAdvance;
    logic [7:0] rxByte;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_CNT,
    ST_WDATA,
    ST_TX,
    ST_IGNORE
  } ctlState_t;

endpackage

// File: rtl/smb_bus_sync.sv
`timescale 1ns/1ps
module smb_bus_sync
  import smb_idx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclSh;
  logic [SYNC_STAGES-1:0] sdaSh;
  logic sclQ;
  logic sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclQ  <= sclSh[MSB];
      sdaQ  <= sdaSh[MSB];
    end
  end

  always_comb begin
    evt.sclRise   = sclSh[MSB] & ~sclQ;
    evt.sclFall   = ~sclSh[MSB] & sclQ;
    evt.startSeen = sclSh[MSB] & sclQ & sdaQ & ~sdaSh[MSB];
    evt.stopSeen  = sclSh[MSB] & sclQ & ~sdaQ & sdaSh[MSB];
    evt.sdaBit    = sdaSh[MSB];
  end

endmodule

// File: rtl/smb_ctrl.sv
`timescale 1ns/1ps
module smb_ctrl
  import smb_idx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] countByte,
  input  logic [7:0] rdByte,
  output dpStrobe_t  strb,
  output logic       sdaPullLow
);

  ctlState_t  state;
  logic [3:0] bitCnt;
  logic       inAck;
  logic [7:0] rxSh;
  logic [7:0] txSh;
  logic [7:0] remain;
  logic       txIsCount;
  logic       sendNext;
  logic       setOffQ;
  logic       wrQ;
  logic       advQ;

  assign strb.setOffset = setOffQ;
  assign strb.wrData    = wrQ;
  assign strb.rdAdvance = advQ;
  assign strb.rxByte    = rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      inAck      <= 1'b0;
      rxSh       <= '0;
      txSh       <= '0;
      remain     <= '0;
      txIsCount  <= 1'b0;
      sendNext   <= 1'b0;
      setOffQ    <= 1'b0;
      wrQ        <= 1'b0;
      advQ       <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      setOffQ <= 1'b0;
      wrQ     <= 1'b0;
      advQ    <= 1'b0;
      if (evt.stopSeen) begin
        state      <= ST_IDLE;
        sdaPullLow <= 1'b0;
        inAck      <= 1'b0;
        bitCnt     <= '0;
        sendNext   <= 1'b0;
      end else if (evt.startSeen) begin
        state      <= ST_ADDR;
        sdaPullLow <= 1'b0;
        inAck      <= 1'b0;
        bitCnt     <= '0;
        sendNext   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE, ST_IGNORE: begin
          end
          ST_TX: begin
            if (evt.sclRise) begin
              if (bitCnt < 4'd8) begin
                txSh   <= {txSh[6:0], 1'b0};
                bitCnt <= bitCnt + 4'd1;
              end else begin
                // host acknowledge slot
                if (!txIsCount) advQ <= 1'b1;
                txIsCount <= 1'b0;
                if (evt.sdaBit) begin
                  state <= ST_IGNORE;
                end else begin
                  sendNext <= 1'b1;
                  bitCnt   <= '0;
                end
              end
            end else if (evt.sclFall) begin
              if (sendNext) begin
                txSh       <= rdByte;
                sdaPullLow <= ~rdByte[7];
                sendNext   <= 1'b0;
              end else if (bitCnt < 4'd8) begin
                sdaPullLow <= ~txSh[7];
              end else begin
                sdaPullLow <= 1'b0;
              end
            end
          end
          default: begin
            if (evt.sclRise && !inAck && bitCnt < 4'd8) begin
              rxSh   <= {rxSh[6:0], evt.sdaBit};
              bitCnt <= bitCnt + 4'd1;
            end else if (evt.sclFall && bitCnt == 4'd8) begin
              if (!inAck) begin
                case (state)
                  ST_ADDR: begin
                    if (rxSh[7:1] == DEV_ADDR) begin
                      inAck      <= 1'b1;
                      sdaPullLow <= 1'b1;
                    end else begin
                      state <= ST_IGNORE;
                    end
                  end
                  ST_OFFS: begin
                    inAck      <= 1'b1;
                    sdaPullLow <= 1'b1;
                    setOffQ    <= 1'b1;
                  end
                  ST_CNT: begin
                    if (rxSh == 8'h00) begin
                      state <= ST_IGNORE;
                    end else begin
                      inAck      <= 1'b1;
                      sdaPullLow <= 1'b1;
                      remain     <= rxSh;
                    end
                  end
                  ST_WDATA: begin
                    if (remain != 8'h00) begin
                      inAck      <= 1'b1;
                      sdaPullLow <= 1'b1;
                      wrQ        <= 1'b1;
                      remain     <= remain - 8'd1;
                    end else begin
                      state <= ST_IGNORE;
                    end
                  end
                  default: begin
                  end
                endcase
              end else begin
                inAck      <= 1'b0;
                bitCnt     <= '0;
                sdaPullLow <= 1'b0;
                case (state)
                  ST_ADDR: begin
                    if (rxSh[0]) begin
                      state      <= ST_TX;
                      txSh       <= countByte;
                      sdaPullLow <= ~countByte[7];
                      txIsCount  <= 1'b1;
                      sendNext   <= 1'b0;
                    end else begin
                      state <= ST_OFFS;
                    end
                  end
                  ST_OFFS: state <= ST_CNT;
                  ST_CNT:  state <= ST_WDATA;
                  default: begin
                  end
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  // SDA moves only after an SCL fall or a bus condition
  assert_sda_edge_R13: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> $past(evt.sclFall || evt.startSeen || evt.stopSeen));

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> (!sdaPullLow && state == ST_IDLE));

  assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (evt.startSeen && !evt.stopSeen) |=> (state == ST_ADDR && !sdaPullLow));

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WDATA && $past(state) == ST_CNT) |-> (remain != 8'h00));

endmodule

// File: rtl/smb_regfile.sv
`timescale 1ns/1ps
module smb_regfile
  import smb_idx_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         IMPL_REGS  = 14,
  parameter int         COUNT_OFS  = 8,
  parameter int         STRAP_OFS  = 6,
  parameter int         ID_OFS     = 7,
  parameter logic [7:0] COUNT_RST  = 8'h08,
  parameter logic [7:0] ID_VAL     = 8'h05,
  parameter logic [7:0] DEVREV_VAL = 8'h20,
  parameter logic [7:0] DEVID_VAL  = 8'h15
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             strapIn,
  input  dpStrobe_t              strb,
  output logic [7:0]             rdByte,
  output logic [7:0]             countByte,
  output logic [IMPL_REGS*8-1:0] ctrlRegs
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int DEVREV_OFS = DEPTH - 2;
  localparam int DEVID_OFS  = DEPTH - 1;

  function automatic logic [7:0] rstVal(input int idx);
    if (idx == COUNT_OFS) return COUNT_RST;
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFE;
      2:       return 8'hFF;
      4:       return 8'h0F;
      6:       return 8'h38;
      9:       return 8'h11;
      10:      return 8'h96;
      11:      return 8'h96;
      12:      return 8'hA7;
      default: return 8'h00;
    endcase
  endfunction

  logic [ADDR_W-1:0] ptr;
  logic [2:0]        strapQ;
  logic [7:0]        viewB [IMPL_REGS];

  // straps follow the pins while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.setOffset) begin
      ptr <= strb.rxByte[ADDR_W-1:0];
    end else if (strb.wrData || strb.rdAdvance) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  for (genvar g = 0; g < IMPL_REGS; g++) begin : gReg
    localparam logic [7:0] RV = rstVal(g);
    if (g == ID_OFS) begin : gId
      assign viewB[g] = ID_VAL;
    end else if (g == STRAP_OFS) begin : gStrap
      logic [7:3] hiQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hiQ <= RV[7:3];
        else if (strb.wrData && ptr == ADDR_W'(g)) hiQ <= strb.rxByte[7:3];
      end
      assign viewB[g] = {hiQ, strapQ};
    end else begin : gPlain
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RV;
        else if (strb.wrData && ptr == ADDR_W'(g)) q <= strb.rxByte;
      end
      assign viewB[g] = q;
    end
    assign ctrlRegs[g*8 +: 8] = viewB[g];
  end

  always_comb begin
    rdByte = 8'h00;
    if (ptr == ADDR_W'(DEVREV_OFS)) begin
      rdByte = DEVREV_VAL;
    end else if (ptr == ADDR_W'(DEVID_OFS)) begin
      rdByte = DEVID_VAL;
    end else begin
      for (int i = 0; i < IMPL_REGS; i++) begin
        if (ptr == ADDR_W'(i)) rdByte = viewB[i];
      end
    end
  end

  assign countByte = viewB[COUNT_OFS];

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setOffset, strb.wrData, strb.rdAdvance}));

  assert_ptr_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrData || strb.rdAdvance) && !strb.setOffset && ptr == {ADDR_W{1'b1}})
      |=> (ptr == '0));

endmodule

// File: rtl/smbus_idx_target.sv
`timescale 1ns/1ps
module smbus_idx_target
  import smb_idx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         ADDR_W      = 6,
  parameter int         IMPL_REGS   = 14,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [2:0]             strapIn,
  output logic                   sdaPullLow,
  output logic [IMPL_REGS*8-1:0] ctrlRegs
);

  busEvt_t    evt;
  dpStrobe_t  strb;
  logic [7:0] rdByte;
  logic [7:0] countByte;

  smb_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .evt(evt)
  );

  smb_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .evt(evt), .countByte(countByte),
    .rdByte(rdByte), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  smb_regfile #(.ADDR_W(ADDR_W), .IMPL_REGS(IMPL_REGS)) regs_i (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .strb(strb),
    .rdByte(rdByte), .countByte(countByte), .ctrlRegs(ctrlRegs)
  );

endmodule

// File: tb/smbus_idx_target_tb_top.sv
`timescale 1ns/1ps
module smbus_idx_target_tb_top;

  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullLow;
  logic [111:0] ctrlRegs;
  wire busSda = mSda & ~sdaPullLow;

  int nCmp = 0;
  int nBad = 0;
  bit cmpEn = 1'b0;
  bit done = 1'b0;
  int model [64];

  always #2.5 clk = ~clk;

  smbus_idx_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .strapIn(STRAP), .sdaPullLow(sdaPullLow), .ctrlRegs(ctrlRegs)
  );

  function automatic int mRead(int a);
    if (a == 6) return (model[6] & 'hF8) | int'(STRAP);
    if (a == 7) return 'h05;
    if (a == 62) return 'h20;
    if (a == 63) return 'h15;
    if (a < 14) return model[a];
    return 0;
  endfunction

  function automatic void mWrite(int a, int b);
    if (a < 14 && a != 7) model[a] = b;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // R12 R2: register output against the model on every clock
  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      for (int i = 0; i < 14; i++) begin
        nCmp++;
        if (int'(ctrlRegs[i*8 +: 8]) != mRead(i)) begin
          nBad++;
          $display("FAIL R2 reg %0d: actual %02h expected %02h",
                   i, ctrlRegs[i*8 +: 8], mRead(i));
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(H);
    mSda = 1'b0; tick(H);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1'b1; tick(H);
      mScl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(H/2);
    ackd = !busSda; tick(H/2);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic readByte(input bit hostAck, output int b);
    logic [7:0] v;
    logic early;
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      mScl = 1'b1; tick(2);
      early = busSda; tick(H-2);
      v[i] = busSda;
      chk("R13", int'(v[i]), int'(early), "SDA stable while SCL high");
      mScl = 1'b0; tick(Q);
    end
    mSda = hostAck ? 1'b0 : 1'b1; tick(Q);
    mScl = 1'b1; tick(H);
    mScl = 1'b0; tick(Q);
    mSda = 1'b1;
    b = int'(v);
  endtask

  task automatic doWrite(string req, int ofsByte, int cnt, int dat[$]);
    bit a;
    int ofs = ofsByte % 64;
    int k = 0;
    busStart();
    writeByte(8'hD2, a); chk("R1", int'(a), 1, "write address ack");
    writeByte(8'(ofsByte), a); chk("R2", int'(a), 1, "index ack");
    writeByte(8'(cnt), a); chk("R3", int'(a), (cnt != 0) ? 1 : 0, "count ack");
    foreach (dat[j]) begin
      bit expAck = (cnt != 0) && (j < cnt);
      cmpEn = 1'b0;
      writeByte(8'(dat[j]), a);
      chk(req, int'(a), int'(expAck), "data ack");
      if (expAck) begin
        mWrite((ofs + k) % 64, dat[j]);
        k++;
      end
      cmpEn = 1'b1;
    end
    busStop();
    chk("R6", int'(sdaPullLow), 0, "SDA released after STOP");
  endtask

  task automatic doRead(string req, int ofsByte, int nData);
    bit a;
    int b;
    int ofs = ofsByte % 64;
    busStart();
    writeByte(8'hD2, a); chk("R1", int'(a), 1, "write address ack");
    writeByte(8'(ofsByte), a); chk("R5", int'(a), 1, "index ack");
    busStart();
    writeByte(8'hD3, a); chk("R1", int'(a), 1, "read address ack");
    readByte(1'b1, b); chk("R5", b, mRead(8), "count byte first");
    for (int k = 0; k < nData; k++) begin
      readByte(k != nData - 1, b);
      chk(req, b, mRead((ofs + k) % 64), "read data");
    end
    chk("R6", int'(sdaPullLow), 0, "SDA released after host NACK");
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    bit a;
    int b;
    for (int i = 0; i < 64; i++) model[i] = 0;
    model[0] = 'hFF; model[1] = 'hFE; model[2] = 'hFF; model[4] = 'h0F;
    model[6] = 'h38; model[8] = 'h08; model[9] = 'h11; model[10] = 'h96;
    model[11] = 'h96; model[12] = 'hA7;
    tick(10);
    rstN = 1'b1;
    tick(4);
    cmpEn = 1'b1;
    chk("R12", int'(sdaPullLow), 0, "SDA released after reset");
    chk("R8", int'(ctrlRegs[6*8 +: 8]), 'h3D, "strap byte after reset");
    chk("R7", int'(ctrlRegs[8*8 +: 8]), 'h08, "count register reset");

    // R2 ordinary block write, then R5 read back
    doWrite("R2", 0, 3, '{'hA5, 'h5A, 'hC3});
    doRead("R5", 0, 3);
    // R4 more data than the count
    doWrite("R4", 9, 2, '{'h11, 'h22, 'h33});
    doRead("R4", 9, 3);
    // R3 zero count
    doWrite("R3", 3, 0, '{'h77});
    doRead("R3", 3, 1);
    // R8 R9 protected bits
    doWrite("R8", 6, 2, '{'h00, 'hFF});
    doRead("R9", 6, 2);
    // R9 R11 identification bytes and read wrap, upper index bits ignored
    doRead("R11", 'hFE, 3);
    // R10 unimplemented index
    doWrite("R10", 20, 1, '{'h99});
    doRead("R10", 20, 1);
    // R11 write across the wrap
    doWrite("R11", 63, 2, '{'h12, 'h34});
    doRead("R11", 63, 2);
    // R7 count register change alters the read preamble
    doWrite("R7", 8, 1, '{'h03});
    doRead("R7", 12, 2);

    // R1 foreign address is ignored
    busStart();
    writeByte(8'hA4, a); chk("R1", int'(a), 0, "foreign address ack");
    writeByte(8'h05, a); chk("R1", int'(a), 0, "byte after foreign address");
    busStop();
    chk("R1", int'(sdaPullLow), 0, "SDA released after foreign address");

    // R6 single-byte read, host stops early
    doRead("R6", 1, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule